// File: doc/BRIEF.md
# Sequential Page-Table Walker

This block turns one virtual address into a physical address by reading a three-level radix page table with 4 KiB pages and 8-byte entries. A request carries the virtual address, the physical base of the top-level table and an access kind. The walker then issues one entry read at a time on a plain request/response memory port. At each level the returned entry either points to the next table or is a leaf that ends the walk.

When the walk completes, the block pulses `done_o` and holds its result until the next completion. A successful result gives the physical address, the leaf entry, the address the leaf was read from, the level where the walk stopped, and a sticky global flag. An unsuccessful result gives one fault code.

Only one translation is in flight at a time. A request is taken only while the walker is idle, and requests that arrive while it is busy are dropped. A caller such as a TLB refill path or a fetch/load-store unit uses the block by raising `req_valid_i` while `busy_o` is low and then waiting for `done_o`.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `busy_o`, `done_o` and `mem_req_o` are low.
- R2: A walk starts at level 2 with the supplied root base. Each entry read is a one-cycle `mem_req_o` pulse with `mem_addr_o` = table base + VPN[level]*8, where VPN[level] = VA[12+9*level +: 9]. No second read is issued before the response to the first has arrived.
- R3: A pointer entry (flag bits R=bit1, W=bit2, X=bit3 all zero, V=bit0 set) found at level 1 or 2 makes the next table base entry[53:10]<<12 and lowers the level by one. A walk therefore makes one read per level it visits.
- R4: A response with `mem_rsp_err_i` high ends the walk with fault code 1 (access).
- R5: An entry with V=0, or with W=1 and R=0, or a pointer entry at level 0, ends the walk with fault code 2 (invalid entry).
- R6: A leaf whose permission bit for the request is clear ends the walk with fault code 4 (permission). Access code 0 needs R, 1 needs W, 2 needs X, and code 3 always faults. This check takes priority over the alignment check of R7.
- R7: A leaf at level L>0 whose PPN (entry[53:10]) has any of its low 9*L bits set ends the walk with fault code 3 (misaligned superpage).
- R8: On success, fault code is 0 and `pa_o` = ((PPN | (VA[38:12] & low-9*L-bit mask)) << 12) | VA[11:0].
- R9: On success, `pte_o` is the leaf entry, `pte_addr_o` is the address it was read from, and `level_o` is L.
- R10: `global_o` is the OR of the G bits (bit 5) of every entry read during the walk, including the leaf.
- R11: `done_o` is a one-cycle pulse. It occurs in the first cycle after the last response, with `busy_o` already low. A request raised while `busy_o` is high is ignored and changes neither the result nor the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Start a walk (taken only when idle) |
| req_va_i | input | 39 | Virtual address to translate |
| req_root_i | input | 56 | Physical base of the top-level table |
| req_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 3 | 0 none, 1 access, 2 invalid, 3 misaligned, 4 permission |
| pa_o | output | 56 | Translated physical address |
| pte_o | output | 64 | Leaf entry |
| pte_addr_o | output | 56 | Address of the leaf entry |
| level_o | output | 2 | Level where the walk stopped |
| global_o | output | 1 | OR of G bits along the walk |
| mem_req_o | output | 1 | Entry read request pulse |
| mem_addr_o | output | 56 | Entry read address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_err_i | input | 1 | Read response error |
| mem_rsp_data_i | input | 64 | Read response data |

## Verification
A wrong level counter or table base shows up on `mem_addr_o` at the very next read. It also shows up as a wrong number of read pulses per walk, so the bench compares the first read address and the read count for every walk. A wrong global accumulator or VPN merge stays hidden until `done_o`, and then appears in `global_o` or in the upper bits of `pa_o`. The vectors therefore mix paths with and without G along the way and use leaves at all three levels, each with a distinct PPN. Fault priority errors show up only in the code reported on `done_o`, so one leaf that is both misaligned and lacks permission is included.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} ptw_st_e;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_ACCESS   = 3'd1,
    FLT_INVALID  = 3'd2,
    FLT_MISALIGN = 3'd3,
    FLT_PERM     = 3'd4
  } ptw_fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int FLG_V = 0;
  localparam int FLG_R = 1;
  localparam int FLG_W = 2;
  localparam int FLG_X = 3;
  localparam int FLG_G = 5;
endpackage

// File: rtl/ptw_index.sv
module ptw_index #(
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int LEVELS = 3,
  parameter int VPN_W  = 9,
  parameter int OFS_W  = 12,
  parameter int PTE_LG = 3,
  parameter int LVL_W  = 2
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [LVL_W-1:0] level_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [VPN_W-1:0] vpn_sl [LEVELS];
  logic [VPN_W-1:0] vpn;

  for (genvar l = 0; l < LEVELS; l++) begin : g_slice
    assign vpn_sl[l] = va_i[OFS_W + l*VPN_W +: VPN_W];
  end

  always_comb begin
    vpn = '0;
    for (int l = 0; l < LEVELS; l++)
      if (level_i == LVL_W'(l)) vpn = vpn_sl[l];
  end

  assign addr_o = base_i + PA_W'({vpn, {PTE_LG{1'b0}}});
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PTE_W   = 64,
  parameter int PA_W    = 56,
  parameter int PPN_LSB = 10,
  parameter int PPN_W   = 44,
  parameter int OFS_W   = 12
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [1:0]       acc_i,
  output logic             invalid_o,
  output logic             pointer_o,
  output logic             perm_ok_o,
  output logic             glob_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic [PA_W-1:0]  next_base_o
);
  logic v, r, w, x;
  assign v = pte_i[FLG_V];
  assign r = pte_i[FLG_R];
  assign w = pte_i[FLG_W];
  assign x = pte_i[FLG_X];

  assign invalid_o = !v || (w && !r);
  assign pointer_o = !r && !w && !x;
  assign glob_o    = pte_i[FLG_G];
  assign ppn_o     = pte_i[PPN_LSB +: PPN_W];
  assign next_base_o = PA_W'({ppn_o, {OFS_W{1'b0}}});

  always_comb begin
    unique case (acc_i)
      ACC_READ:  perm_ok_o = r;
      ACC_WRITE: perm_ok_o = w;
      ACC_EXEC:  perm_ok_o = x;
      default:   perm_ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptw_leaf_map.sv
module ptw_leaf_map #(
  parameter int VA_W   = 39,
  parameter int PA_W   = 56,
  parameter int PPN_W  = 44,
  parameter int LEVELS = 3,
  parameter int VPN_W  = 9,
  parameter int OFS_W  = 12,
  parameter int LVL_W  = 2
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic [PPN_W-1:0] ppn_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             misalign_o,
  output logic [PA_W-1:0]  pa_o
);
  localparam int VPNS_W = VA_W - OFS_W;

  logic [PPN_W-1:0] lvl_mask [LEVELS];
  logic [PPN_W-1:0] mask;
  logic [PPN_W-1:0] vpns_ext;

  for (genvar l = 0; l < LEVELS; l++) begin : g_mask
    assign lvl_mask[l] = ~({PPN_W{1'b1}} << (l*VPN_W));
  end

  always_comb begin
    mask = '0;
    for (int l = 0; l < LEVELS; l++)
      if (level_i == LVL_W'(l)) mask = lvl_mask[l];
  end

  assign vpns_ext   = PPN_W'(va_i[VA_W-1:OFS_W]);
  assign misalign_o = |(ppn_i & mask);
  assign pa_o       = PA_W'({ppn_i | (vpns_ext & mask), va_i[OFS_W-1:0]});

  if (VPNS_W > PPN_W) begin : g_bad_width
    initial $error("vpn field wider than ppn");
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int LEVELS  = 3,
  parameter int VPN_W   = 9,
  parameter int OFS_W   = 12,
  parameter int PA_W    = 56,
  parameter int PTE_W   = 64,
  parameter int PPN_LSB = 10,
  parameter int PTE_LG  = 3,
  localparam int VA_W   = OFS_W + LEVELS*VPN_W,
  localparam int PPN_W  = PA_W - OFS_W,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [PA_W-1:0]   req_root_i,
  input  logic [1:0]        req_acc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2:0]        fault_o,
  output logic [PA_W-1:0]   pa_o,
  output logic [PTE_W-1:0]  pte_o,
  output logic [PA_W-1:0]   pte_addr_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              global_o,
  output logic              mem_req_o,
  output logic [PA_W-1:0]   mem_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_err_i,
  input  logic [PTE_W-1:0]  mem_rsp_data_i
);
  ptw_st_e          st_q;
  logic [VA_W-1:0]  va_q;
  logic [1:0]       acc_q;
  logic [PA_W-1:0]  base_q;
  logic [LVL_W-1:0] lvl_q;
  logic             glob_acc_q;

  logic             done_q, glob_out_q;
  ptw_fault_e       fault_q;
  logic [PA_W-1:0]  pa_q, paddr_q;
  logic [PTE_W-1:0] pte_q;
  logic [LVL_W-1:0] lvl_out_q;

  logic [PA_W-1:0]  cur_addr, next_base, leaf_pa;
  logic [PPN_W-1:0] ppn;
  logic             invalid, pointer, perm_ok, pte_g, misalign;
  logic             rsp_in, descend, glob_n;
  ptw_fault_e       flt_n;

  ptw_index #(
    .VA_W(VA_W), .PA_W(PA_W), .LEVELS(LEVELS), .VPN_W(VPN_W),
    .OFS_W(OFS_W), .PTE_LG(PTE_LG), .LVL_W(LVL_W)
  ) u_index (
    .va_i(va_q), .base_i(base_q), .level_i(lvl_q), .addr_o(cur_addr)
  );

  ptw_pte_check #(
    .PTE_W(PTE_W), .PA_W(PA_W), .PPN_LSB(PPN_LSB), .PPN_W(PPN_W), .OFS_W(OFS_W)
  ) u_check (
    .pte_i(mem_rsp_data_i), .acc_i(acc_q), .invalid_o(invalid),
    .pointer_o(pointer), .perm_ok_o(perm_ok), .glob_o(pte_g),
    .ppn_o(ppn), .next_base_o(next_base)
  );

  ptw_leaf_map #(
    .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .LEVELS(LEVELS),
    .VPN_W(VPN_W), .OFS_W(OFS_W), .LVL_W(LVL_W)
  ) u_leaf (
    .va_i(va_q), .ppn_i(ppn), .level_i(lvl_q),
    .misalign_o(misalign), .pa_o(leaf_pa)
  );

  assign rsp_in  = (st_q == ST_WAIT) && mem_rsp_valid_i;
  assign glob_n  = glob_acc_q | pte_g;
  assign descend = !mem_rsp_err_i && !invalid && pointer && (lvl_q != '0);

  // fault priority: bus error, invalid, pointer at level 0, permission, alignment
  always_comb begin
    if (mem_rsp_err_i)      flt_n = FLT_ACCESS;
    else if (invalid)       flt_n = FLT_INVALID;
    else if (pointer)       flt_n = FLT_INVALID;
    else if (!perm_ok)      flt_n = FLT_PERM;
    else if (misalign)      flt_n = FLT_MISALIGN;
    else                    flt_n = FLT_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      va_q       <= '0;
      acc_q      <= '0;
      base_q     <= '0;
      lvl_q      <= '0;
      glob_acc_q <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= FLT_NONE;
      pa_q       <= '0;
      pte_q      <= '0;
      paddr_q    <= '0;
      lvl_out_q  <= '0;
      glob_out_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q       <= req_va_i;
          acc_q      <= req_acc_i;
          base_q     <= req_root_i;
          lvl_q      <= LVL_W'(LEVELS-1);
          glob_acc_q <= 1'b0;
          st_q       <= ST_ISSUE;
        end
        ST_ISSUE: st_q <= ST_WAIT;
        ST_WAIT: if (rsp_in) begin
          if (descend) begin
            base_q     <= next_base;
            lvl_q      <= lvl_q - LVL_W'(1);
            glob_acc_q <= glob_n;
            st_q       <= ST_ISSUE;
          end else begin
            fault_q    <= flt_n;
            pa_q       <= leaf_pa;
            pte_q      <= mem_rsp_data_i;
            paddr_q    <= cur_addr;
            lvl_out_q  <= lvl_q;
            glob_out_q <= glob_n;
            done_q     <= 1'b1;
            st_q       <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign pa_o       = pa_q;
  assign pte_o      = pte_q;
  assign pte_addr_o = paddr_q;
  assign level_o    = lvl_out_q;
  assign global_o   = glob_out_q;
  assign mem_req_o  = (st_q == ST_ISSUE);
  assign mem_addr_o = cur_addr;

  a_r2_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  a_r2_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  a_r3_descend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_in && descend) |=> (mem_req_o && lvl_q == $past(lvl_q) - LVL_W'(1)));
  a_r4_err_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_in && mem_rsp_err_i) |=> (done_o && fault_o == FLT_ACCESS));
  a_r8_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o == FLT_NONE) |-> pa_o[OFS_W-1:0] == va_q[OFS_W-1:0]);
  a_r9_level_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> level_o < LVL_W'(LEVELS));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [55:0] ROOT = 56'h1000;
  localparam logic [55:0] ERR_ADDR = 56'h3038;

  typedef struct packed {
    logic [38:0] va;
    logic [1:0]  acc;
    logic [2:0]  flt;
    logic [55:0] pa;
    logic [63:0] pte;
    logic [55:0] paddr;
    logic [1:0]  lvl;
    logic        glob;
    logic [2:0]  nrd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{39'h0ABC,       2'd0, 3'd0, 56'h12345ABC, 64'h48D14C7, 56'h3000, 2'd0, 1'b0, 3'd3},
    '{39'h0ABC,       2'd1, 3'd0, 56'h12345ABC, 64'h48D14C7, 56'h3000, 2'd0, 1'b0, 3'd3},
    '{39'h0ABC,       2'd2, 3'd4, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd3},
    '{39'h0ABC,       2'd3, 3'd4, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd3},
    '{39'h2010,       2'd2, 3'd0, 56'h777010, 64'h1DDC49, 56'h3010, 2'd0, 1'b0, 3'd3},
    '{39'h2010,       2'd0, 3'd4, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd3},
    '{39'h1000,       2'd0, 3'd2, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd3},
    '{39'h7000,       2'd0, 3'd1, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd3},
    '{39'h3123,       2'd0, 3'd0, 56'h888123, 64'h222023, 56'h3018, 2'd0, 1'b1, 3'd3},
    '{39'h255678,     2'd0, 3'd0, 56'h455678, 64'h100043, 56'h2008, 2'd1, 1'b0, 3'd2},
    '{39'h255678,     2'd1, 3'd4, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd2},
    '{39'h400000,     2'd0, 3'd3, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd2},
    '{39'h746F2345,   2'd2, 3'd0, 56'hB46F2345, 64'h200000EF, 56'h1008, 2'd2, 1'b1, 3'd1},
    '{39'h80000000,   2'd0, 3'd3, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd1},
    '{39'hC0000000,   2'd0, 3'd2, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd1},
    '{39'h100000000,  2'd0, 3'd2, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd1},
    '{39'h140000ABC,  2'd0, 3'd0, 56'h12345ABC, 64'h48D14C7, 56'h3000, 2'd0, 1'b1, 3'd3},
    '{39'h80000000,   2'd3, 3'd4, 56'h0, 64'h0, 56'h0, 2'd0, 1'b0, 3'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [38:0] req_va = '0;
  logic [55:0] req_root = '0;
  logic [1:0]  req_acc = '0;
  logic busy, done, global_f, mem_req;
  logic [2:0]  fault;
  logic [55:0] pa, pte_addr, mem_addr;
  logic [63:0] pte;
  logic [1:0]  level;
  logic rsp_v = 1'b0, rsp_e = 1'b0;
  logic [63:0] rsp_d = '0;

  int checks = 0, fails = 0, cyc = 0;
  int lat = 1, pend = 0, rd_cnt = 0;
  logic [55:0] pend_addr = '0, first_addr = '0;
  logic [63:0] mem [longint];

  logic [2:0]  o_flt;
  logic [55:0] o_pa, o_paddr;
  logic [63:0] o_pte;
  logic [1:0]  o_lvl;
  logic        o_glob, o_timeout;

  always #(CLK_PERIOD/2) clk = ~clk;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_va_i(req_va),
    .req_root_i(req_root), .req_acc_i(req_acc), .busy_o(busy), .done_o(done),
    .fault_o(fault), .pa_o(pa), .pte_o(pte), .pte_addr_o(pte_addr),
    .level_o(level), .global_o(global_f), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rsp_valid_i(rsp_v), .mem_rsp_err_i(rsp_e),
    .mem_rsp_data_i(rsp_d)
  );

  // memory model: response lat negedges after the request is seen
  always @(negedge clk) begin
    rsp_v = 1'b0; rsp_e = 1'b0; rsp_d = '0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        rsp_v = 1'b1;
        rsp_e = (pend_addr == ERR_ADDR);
        rsp_d = mem.exists(longint'(pend_addr)) ? mem[longint'(pend_addr)] : 64'h0;
      end
    end
    if (rst_n && mem_req) begin
      pend = lat;
      pend_addr = mem_addr;
      if (rd_cnt == 0) first_addr = mem_addr;
      rd_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string ftag(input logic [2:0] f);
    case (f)
      3'd1: return "R4 access fault";
      3'd2: return "R5 invalid entry";
      3'd3: return "R7 misaligned";
      3'd4: return "R6 permission";
      default: return "R8 success";
    endcase
  endfunction

  task automatic run_walk(input logic [38:0] va, input logic [1:0] acc, input bit hold);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1; req_va = va; req_root = ROOT; req_acc = acc;
    o_timeout = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (hold) req_va = 39'h746F2345;
    for (int i = 0; i < 200; i++) begin
      if (done) begin
        o_timeout = 1'b0;
        o_flt = fault; o_pa = pa; o_pte = pte; o_paddr = pte_addr;
        o_lvl = level; o_glob = global_f;
        req_valid = 1'b0;
        break;
      end
      req_valid = hold & busy;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(!o_timeout, "R11 completion", 64'(o_timeout), 64'h0);
    @(negedge clk);
    chk(!done, "R11 done single pulse", 64'(done), 64'h0);
  endtask

  task automatic check_vec(input vec_t v);
    chk(o_flt == v.flt, ftag(v.flt), 64'(o_flt), 64'(v.flt));
    chk(rd_cnt == int'(v.nrd), "R3 reads per walk", 64'(rd_cnt), 64'(v.nrd));
    chk(first_addr == ROOT + 56'(v.va[38:30]) * 8, "R2 first read address",
        64'(first_addr), 64'(ROOT + 56'(v.va[38:30]) * 8));
    if (v.flt == 3'd0) begin
      chk(o_pa == v.pa, "R8 physical address", 64'(o_pa), 64'(v.pa));
      chk(o_pte == v.pte, "R9 leaf entry", o_pte, v.pte);
      chk(o_paddr == v.paddr, "R9 entry address", 64'(o_paddr), 64'(v.paddr));
      chk(o_lvl == v.lvl, "R9 level", 64'(o_lvl), 64'(v.lvl));
      chk(o_glob == v.glob, "R10 global", 64'(o_glob), 64'(v.glob));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    mem[64'h1000] = 64'h801;
    mem[64'h1008] = 64'h200000EF;
    mem[64'h1010] = 64'h200004CF;
    mem[64'h1018] = 64'h0;
    mem[64'h1020] = 64'h05;
    mem[64'h1028] = 64'h1021;
    mem[64'h2000] = 64'hC01;
    mem[64'h2008] = 64'h100043;
    mem[64'h2010] = 64'h100443;
    mem[64'h4000] = 64'hC01;
    mem[64'h3000] = 64'h48D14C7;
    mem[64'h3008] = 64'h1401;
    mem[64'h3010] = 64'h1DDC49;
    mem[64'h3018] = 64'h222023;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 in reset", {61'h0, busy, done, mem_req}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 after reset", {61'h0, busy, done, mem_req}, 64'h0);

    for (int k = 0; k < NV; k++) begin
      run_walk(VECS[k].va, VECS[k].acc, 1'b0);
      check_vec(VECS[k]);
    end

    // R11: request held high while busy is ignored
    run_walk(VECS[0].va, VECS[0].acc, 1'b1);
    check_vec(VECS[0]);
    repeat (4) begin
      @(negedge clk);
      chk(!busy && !done, "R11 no extra walk", {62'h0, busy, done}, 64'h0);
    end

    // R2: longer memory latency keeps a single read outstanding
    lat = 3;
    run_walk(VECS[16].va, VECS[16].acc, 1'b0);
    check_vec(VECS[16]);
    run_walk(VECS[9].va, VECS[9].acc, 1'b0);
    check_vec(VECS[9]);
    lat = 1;

    // R4: error response after a long latency
    lat = 2;
    run_walk(VECS[7].va, VECS[7].acc, 1'b0);
    check_vec(VECS[7]);
    lat = 1;

    // R1: reset in the middle of a walk returns to idle
    @(negedge clk);
    req_valid = 1'b1; req_va = VECS[0].va; req_root = ROOT; req_acc = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 mid-walk reset", {61'h0, busy, done, mem_req}, 64'h0);
    pend = 0;
    rst_n = 1'b1;
    @(negedge clk);
    run_walk(VECS[12].va, VECS[12].acc, 1'b0);
    check_vec(VECS[12]);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule